// File: doc/BRIEF.md
# Strided Vector Load Engine over Interleaved Banks

The engine accepts one vector load command (a start word address, a word stride and an element count). It walks the element addresses `base + i*stride` in order and issues at most one read per clock to a memory built from single-ported banks. A bank is chosen by the word address modulo the bank count. After a bank is read it stays occupied for a fixed number of cycles. When the next element falls on an occupied bank, the engine waits, and it counts each waiting cycle. The memory returns each read a fixed number of cycles after issue. The engine passes every returned element out with its element index.

Because reads leave in element order and the latency is fixed, results come back in element order even when issue stalls. One cycle after the last element arrives, the engine raises a completion pulse. It then holds the total load time and the number of stall cycles until the next command. Strides that bring a bank back before its busy time ends produce stalls, so the load time shows how the stride and the bank count interact.

Top module: `vld_strided_unit`

## Requirements
- R1: After reset, `ld_busy`, `ld_done`, `mem_rd_en` and `res_valid` are 0, and `ld_cycles` and `ld_stalls` read 0.
- R2: Element i is read at word address `base + i*stride` (16-bit wraparound). Reads leave in increasing element order, and the target bank is the address modulo 8 (the low three address bits).
- R3: No more than one read is issued per cycle. If no bank is occupied, element i leaves in cycle i after the command edge, so a 64-element unit-stride load reports 76 cycles.
- R4: A bank that was read in cycle c is not read again before cycle c+6. A 64-element load with stride 32 puts every read on one bank and reports 391 cycles.
- R5: Read data arrives on `mem_rd_data` 12 cycles after its read is issued. Each element appears on `res_data` in that cycle, with `res_valid` high and `res_idx` equal to its element index, in element order.
- R6: `ld_done` is a one-cycle pulse one cycle after the last element returns. At that point `ld_cycles` holds the number of clock edges from the command edge up to that pulse, and `ld_busy` is 0.
- R7: `ld_stalls` counts the cycles in which an element was ready to issue but its bank was occupied.
- R8: A command with element count 0 makes no memory read. It raises `ld_done` in the next cycle with `ld_cycles` = 0 and `ld_stalls` = 0.
- R9: A command presented while `ld_busy` is 1 is ignored, and the load in progress completes unchanged.
- R10: A stride whose bank revisit distance LCM(stride, 8)/stride is at least 6 (for example stride 3) causes no stalls. Stride 2 revisits a bank after 4 reads and stalls 2 cycles per revisit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, accepted when idle |
| cmd_base | input | 16 | Word address of element 0 |
| cmd_stride | input | 16 | Word distance between elements |
| cmd_count | input | 7 | Element count, 0 to 64 |
| ld_busy | output | 1 | A load is in progress |
| mem_rd_en | output | 1 | Read issued this cycle |
| mem_rd_addr | output | 16 | Word address of the read |
| mem_rd_data | input | 32 | Read data, valid 12 cycles after issue |
| res_valid | output | 1 | Element returned this cycle |
| res_idx | output | 7 | Element index of the returned element |
| res_data | output | 32 | Returned element value |
| ld_done | output | 1 | One-cycle completion pulse |
| ld_cycles | output | 16 | Total cycles of the last load |
| ld_stalls | output | 16 | Bank-conflict stall cycles of the last load |

## Verification
The command is sampled at one clock edge, and the bench numbers the cycles after that edge from 0. Element i is due on `mem_rd_en` in its computed issue cycle t_i. Its data is due on `res_valid` in cycle t_i+12, and `ld_done` is due in cycle t_last+13. For a zero-length command `ld_done` is due in cycle 0. The bench derives t_i from its own bank occupancy timeline for the stride and samples every output at the falling edge inside the cycle in question. A result that arrives one cycle early or late therefore fails its check. The cycle after the pulse is also sampled, to confirm that `ld_done` has fallen.

// File: rtl/vld_pkg.sv
package vld_pkg;

  typedef enum logic {LS_IDLE, LS_RUN} ld_state_e;

  // bank that serves a word address
  function automatic int unsigned bank_sel(input logic [31:0] addr, input int unsigned nbank);
    return addr % nbank;
  endfunction

endpackage

// File: rtl/vld_bank_timers.sv
module vld_bank_timers #(
  parameter int NBANK = 8,
  parameter int BUSY  = 6,
  localparam int BW   = $clog2(NBANK),
  localparam int TMW  = $clog2(BUSY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_en,
  input  logic [BW-1:0]    issue_bank,
  output logic [NBANK-1:0] bank_free
);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [TMW-1:0] cnt;
    logic           hit;

    assign hit = issue_en && (issue_bank == BW'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (hit)        cnt <= TMW'(BUSY - 1);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign bank_free[b] = (cnt == '0);

    // R4: a read reaches a bank only after its busy time has run out
    p_bank_idle_on_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> cnt == '0);
  end

endmodule

// File: rtl/vld_return_pipe.sv
module vld_return_pipe #(
  parameter int LAT = 12,
  parameter int CW  = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [CW-1:0] in_idx,
  output logic          out_valid,
  output logic [CW-1:0] out_idx
);

  logic [LAT-1:0] vld;
  logic [CW-1:0]  idx [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else begin
      vld[0] <= in_valid;
      for (int k = 1; k < LAT; k++) vld[k] <= vld[k-1];
    end
  end

  always_ff @(posedge clk) begin
    idx[0] <= in_idx;
    for (int k = 1; k < LAT; k++) idx[k] <= idx[k-1];
  end

  assign out_valid = vld[LAT-1];
  assign out_idx   = idx[LAT-1];

endmodule

// File: rtl/vld_issue_ctrl.sv
module vld_issue_ctrl
  import vld_pkg::*;
#(
  parameter int NBANK = 8,
  parameter int AW    = 16,
  parameter int CW    = 7,
  parameter int TW    = 16,
  localparam int BW   = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [AW-1:0]    cmd_base,
  input  logic [AW-1:0]    cmd_stride,
  input  logic [CW-1:0]    cmd_count,
  input  logic [NBANK-1:0] bank_free,
  input  logic             ret_valid,
  input  logic [CW-1:0]    ret_idx,
  output logic             mem_rd_en,
  output logic [AW-1:0]    mem_rd_addr,
  output logic [BW-1:0]    issue_bank,
  output logic [CW-1:0]    issue_idx,
  output logic             ld_busy,
  output logic             ld_done,
  output logic [TW-1:0]    ld_cycles,
  output logic [TW-1:0]    ld_stalls
);

  ld_state_e     state_q;
  logic [AW-1:0] addr_q, stride_q;
  logic [CW-1:0] total_q, iss_idx_q, ret_cnt_q;
  logic [TW-1:0] cyc_q, stall_q;
  logic          done_q;

  // named events for the assertions
  logic start_acc, issue_pending, issue_fire, stall_evt, last_ret;

  assign start_acc     = cmd_valid && (state_q == LS_IDLE);
  assign issue_bank    = BW'(bank_sel(32'(addr_q), NBANK));
  assign issue_pending = (state_q == LS_RUN) && (iss_idx_q != total_q);
  assign issue_fire    = issue_pending && bank_free[issue_bank];
  assign stall_evt     = issue_pending && !bank_free[issue_bank];
  assign last_ret      = ret_valid && (ret_idx == total_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= LS_IDLE;
      addr_q    <= '0;
      stride_q  <= '0;
      total_q   <= '0;
      iss_idx_q <= '0;
      ret_cnt_q <= '0;
      cyc_q     <= '0;
      stall_q   <= '0;
      done_q    <= 1'b0;
    end else if (start_acc) begin
      addr_q    <= cmd_base;
      stride_q  <= cmd_stride;
      total_q   <= cmd_count;
      iss_idx_q <= '0;
      ret_cnt_q <= '0;
      cyc_q     <= '0;
      stall_q   <= '0;
      done_q    <= (cmd_count == '0);
      state_q   <= (cmd_count == '0) ? LS_IDLE : LS_RUN;
    end else begin
      done_q <= 1'b0;
      if (state_q == LS_RUN) cyc_q <= cyc_q + 1'b1;
      if (issue_fire) begin
        addr_q    <= addr_q + stride_q;
        iss_idx_q <= iss_idx_q + 1'b1;
      end
      if (stall_evt) stall_q   <= stall_q + 1'b1;
      if (ret_valid) ret_cnt_q <= ret_cnt_q + 1'b1;
      if (last_ret) begin
        state_q <= LS_IDLE;
        done_q  <= 1'b1;
      end
    end
  end

  assign mem_rd_en   = issue_fire;
  assign mem_rd_addr = addr_q;
  assign issue_idx   = iss_idx_q;
  assign ld_busy     = (state_q == LS_RUN);
  assign ld_done     = done_q;
  assign ld_cycles   = cyc_q;
  assign ld_stalls   = stall_q;

  // R5: returns arrive in element order
  p_ret_in_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> ret_idx == ret_cnt_q);

  // R5: no data returns outside a load
  p_ret_inside_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> ld_busy);

  // R6: completion leaves the engine idle and lasts one cycle
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |-> !ld_busy);
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done && !cmd_valid |=> !ld_done);

  // R8: an empty command completes at once with no reads
  p_zero_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc && cmd_count == '0 |=> ld_done && !ld_busy && !mem_rd_en);

  // R9: a command during a load does not disturb it
  p_cmd_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_busy && cmd_valid |=> $stable(total_q) && $stable(stride_q));

endmodule

// File: rtl/vld_strided_unit.sv
module vld_strided_unit #(
  parameter int NBANK  = 8,
  parameter int BUSY   = 6,
  parameter int LAT    = 12,
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int MAXLEN = 64,
  parameter int TW     = 16,
  localparam int BW    = $clog2(NBANK),
  localparam int CW    = $clog2(MAXLEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [AW-1:0] cmd_base,
  input  logic [AW-1:0] cmd_stride,
  input  logic [CW-1:0] cmd_count,
  output logic          ld_busy,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic          res_valid,
  output logic [CW-1:0] res_idx,
  output logic [DW-1:0] res_data,
  output logic          ld_done,
  output logic [TW-1:0] ld_cycles,
  output logic [TW-1:0] ld_stalls
);

  logic [NBANK-1:0] bank_free;
  logic [BW-1:0]    issue_bank;
  logic [CW-1:0]    issue_idx;
  logic             ret_valid;
  logic [CW-1:0]    ret_idx;

  vld_issue_ctrl #(.NBANK(NBANK), .AW(AW), .CW(CW), .TW(TW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_base(cmd_base), .cmd_stride(cmd_stride), .cmd_count(cmd_count),
    .bank_free(bank_free), .ret_valid(ret_valid), .ret_idx(ret_idx),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .issue_bank(issue_bank), .issue_idx(issue_idx),
    .ld_busy(ld_busy), .ld_done(ld_done), .ld_cycles(ld_cycles), .ld_stalls(ld_stalls)
  );

  vld_bank_timers #(.NBANK(NBANK), .BUSY(BUSY)) u_timers (
    .clk(clk), .rst_n(rst_n),
    .issue_en(mem_rd_en), .issue_bank(issue_bank), .bank_free(bank_free)
  );

  vld_return_pipe #(.LAT(LAT), .CW(CW)) u_ret (
    .clk(clk), .rst_n(rst_n),
    .in_valid(mem_rd_en), .in_idx(issue_idx),
    .out_valid(ret_valid), .out_idx(ret_idx)
  );

  assign res_valid = ret_valid;
  assign res_idx   = ret_idx;
  assign res_data  = mem_rd_data;

endmodule

// File: tb/sim_vld_strided_unit.sv
`timescale 1ns/1ps
module sim_vld_strided_unit;

  localparam int LAT = 12;
  localparam int BUSY = 6;
  localparam int NB = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_base = '0, cmd_stride = '0;
  logic [6:0]  cmd_count = '0;
  logic        ld_busy, mem_rd_en, res_valid, ld_done;
  logic [15:0] mem_rd_addr, ld_cycles, ld_stalls;
  logic [31:0] mem_rd_data, res_data;
  logic [6:0]  res_idx;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  vld_strided_unit u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_base(cmd_base),
    .cmd_stride(cmd_stride), .cmd_count(cmd_count), .ld_busy(ld_busy),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .res_valid(res_valid), .res_idx(res_idx), .res_data(res_data),
    .ld_done(ld_done), .ld_cycles(ld_cycles), .ld_stalls(ld_stalls)
  );

  function automatic logic [31:0] mval(input logic [15:0] a);
    return {a ^ 16'h5A3C, a};
  endfunction

  // memory model: fixed latency delay line of addresses
  logic [15:0] pa [LAT];
  always @(posedge clk) begin
    pa[0] <= mem_rd_addr;
    for (int k = 1; k < LAT; k++) pa[k] <= pa[k-1];
  end
  assign mem_rd_data = mval(pa[LAT-1]);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_load(input logic [15:0] base, input logic [15:0] stride,
                          input int cnt, input int inject_at, input string req);
    int t_exp [64];
    int freeb [NB];
    int prev, stall_exp, total, k, ni, nr;
    bit seen;
    logic [15:0] ea;
    for (int b = 0; b < NB; b++) freeb[b] = 0;
    prev = -1; stall_exp = 0;
    for (int i = 0; i < cnt; i++) begin
      int tt, bk;
      ea = base + 16'(i) * stride;
      bk = int'(ea) % NB;
      tt = prev + 1;
      if (freeb[bk] > tt) tt = freeb[bk];
      stall_exp += tt - (prev + 1);
      t_exp[i] = tt;
      freeb[bk] = tt + BUSY;
      prev = tt;
    end
    total = (cnt == 0) ? 0 : prev + LAT + 1;

    @(negedge clk);
    cmd_valid = 1'b1; cmd_base = base; cmd_stride = stride; cmd_count = 7'(cnt);
    @(negedge clk);
    cmd_valid = 1'b0;
    k = 0; ni = 0; nr = 0; seen = 0;
    chk(ld_busy == (cnt != 0), {req, " busy after command"}, int'(ld_busy), int'(cnt != 0));
    while (k < 3000) begin
      if (k == inject_at) begin
        cmd_valid = 1'b1; cmd_base = 16'h7777; cmd_stride = 16'd5; cmd_count = 7'd3;
      end
      if (k == inject_at + 1) cmd_valid = 1'b0;
      if (mem_rd_en) begin
        ea = base + 16'(ni) * stride;
        chk(ni < cnt && mem_rd_addr == ea, {req, " R2 read address"}, int'(mem_rd_addr), int'(ea));
        chk(ni < cnt && k == t_exp[ni], {req, " R3/R4 issue cycle"}, k, (ni < cnt) ? t_exp[ni] : -1);
        ni++;
      end
      if (res_valid) begin
        ea = base + 16'(nr) * stride;
        chk(int'(res_idx) == nr && res_data == mval(ea), {req, " R5 element order/data"},
            int'(res_idx), nr);
        chk(nr < cnt && k == t_exp[nr] + LAT, {req, " R5 return cycle"}, k,
            (nr < cnt) ? t_exp[nr] + LAT : -1);
        nr++;
      end
      if (ld_done) begin
        seen = 1;
        chk(k == total, {req, " R6 done cycle"}, k, total);
        chk(int'(ld_cycles) == total, {req, " R6 ld_cycles"}, int'(ld_cycles), total);
        chk(int'(ld_stalls) == stall_exp, {req, " R7 ld_stalls"}, int'(ld_stalls), stall_exp);
        chk(!ld_busy, {req, " R6 idle at done"}, int'(ld_busy), 0);
        break;
      end
      k++;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk(seen, {req, " R6 done seen"}, int'(seen), 1);
    chk(ni == cnt && nr == cnt, {req, " R2 element count"}, ni * 1000 + nr, cnt * 1000 + cnt);
    @(negedge clk);
    chk(!ld_done, {req, " R6 single pulse"}, int'(ld_done), 0);
    chk(!mem_rd_en && !res_valid, {req, " R9 no extra traffic"}, int'(mem_rd_en) + int'(res_valid), 0);
  endtask

  task automatic t_reset;
    chk(!ld_busy && !ld_done && !mem_rd_en && !res_valid, "R1 idle outputs",
        int'({ld_busy, ld_done, mem_rd_en, res_valid}), 0);
    chk(ld_cycles == 0 && ld_stalls == 0, "R1 counters", int'(ld_cycles) + int'(ld_stalls), 0);
  endtask

  task automatic t_known_totals;
    run_load(16'h0100, 16'd1, 64, -1, "R3 stride1");
    chk(ld_cycles == 16'd76, "R3 unit stride total", int'(ld_cycles), 76);
    run_load(16'h0040, 16'd32, 64, -1, "R4 stride32");
    chk(ld_cycles == 16'd391, "R4 same bank total", int'(ld_cycles), 391);
    chk(ld_stalls == 16'd315, "R7 same bank stalls", int'(ld_stalls), 315);
  endtask

  task automatic t_lcm;
    run_load(16'h0003, 16'd3, 20, -1, "R10 stride3");
    chk(ld_stalls == 0 && ld_cycles == 16'd32, "R10 stride3 no stalls", int'(ld_stalls), 0);
    run_load(16'h0200, 16'd2, 16, -1, "R10 stride2");
    chk(ld_stalls == 16'd6 && ld_cycles == 16'd34, "R10 stride2 stalls", int'(ld_stalls), 6);
  endtask

  task automatic t_zero;
    run_load(16'h1234, 16'd1, 0, -1, "R8 empty");
  endtask

  task automatic t_ignore;
    run_load(16'h0500, 16'd4, 8, 3, "R9 busy command");
  endtask

  task automatic t_wrap;
    run_load(16'hFFFA, 16'd1, 12, -1, "R2 wrap");
    run_load(16'h0011, 16'd8, 10, -1, "R4 stride8");
  endtask

  initial begin : wdog
    repeat (60000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_known_totals();
    t_lcm();
    t_zero();
    t_ignore();
    t_wrap();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule